// File: doc/BRIEF.md
# Bus Error Capture Register

This block records the first error event that appears on a memory or system bus. It holds that event until software acknowledges it, and it keeps an interrupt raised for the whole time. An event arrives as a one-cycle strobe. The strobe carries four things: whether the CPU or a DMA agent was on the bus, whether the cycle was a read or a write, whether the memory reported an ECC failure, and the word address of the access. Two 16-bit syndrome halves arrive alongside the event, one for each memory bank. The block stores both halves when it stores the event.

Software reaches the block through a small register port. It has two words: the error address word at index 0 and the syndrome word at index 1. Any write to index 0 acknowledges the error. For an ECC failure on a read, the memory pipeline has already moved on by the time the failure is known. The block therefore rewinds the low part of the address before storing it, so that the stored address names the failing word. The block also classifies the stored error and presents the syndrome half of the bank that the stored address points to.

Top module: `bus_err_capture`

## Requirements
- R1: A strobe seen while no error is held is stored at that clock edge, and `irq` is 1 from then on. The error address word has these fields: bit 31 valid, bit 30 agent (1 = CPU, 0 = DMA), bit 29 write cycle, bit 28 ECC error, bits 27:0 word address.
- R2: While an error is held, further strobes are ignored. Both register words keep their values.
- R3: A write to index 0 clears both words and `irq` at that edge, whatever the write data. If a strobe arrives in the same cycle as that write, the new event is stored instead of the clear.
- R4: For an ECC error on a read, the stored address keeps bits 27:12. Bits 11:0 become the incoming bits 11:0 minus 5, modulo 4096.
- R5: For a non-ECC error, and for an ECC error on a write, the address is stored unchanged.
- R6: `err_class` reports the stored error: 0 when nothing is held, 1 for a CPU timeout (CPU, no ECC), 2 for a DMA overrun (DMA, no ECC), 3 for an ECC error.
- R7: The syndrome word holds the low-bank half in bits 15:0 and the high-bank half in bits 31:16. Each half keeps bit 15 (valid), bit 14 (single error) and bits 6:0 (syndrome) as they were at the event. Bits 13:7 of each half read as 0.
- R8: `bank_syn` shows the low half when bit 0 of the stored word address is 0 (byte-address bit 2 clear), shows the high half when that bit is 1, and is 0 when nothing is held.
- R9: A write to index 1 changes nothing.
- R10: After reset, `irq` is 0, `err_class` is 0, `bank_syn` is 0 and both words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_strobe | input | 1 | Error event, one cycle |
| ev_cpu | input | 1 | Agent of the event: 1 = CPU, 0 = DMA |
| ev_write | input | 1 | The faulting cycle was a write |
| ev_ecc | input | 1 | The event is an ECC failure |
| ev_addr | input | 28 | Word address of the faulting access |
| syn_lo | input | 16 | Low-bank syndrome half |
| syn_hi | input | 16 | High-bank syndrome half |
| reg_addr | input | 1 | Register index: 0 = error address, 1 = syndrome |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data (its value is ignored) |
| reg_rdata | output | 32 | Read data of the selected register |
| irq | output | 1 | Error pending |
| err_class | output | 2 | Class of the stored error |
| bank_syn | output | 16 | Syndrome half of the addressed bank |

## Verification
All stored results appear one clock edge after the strobe or the write that causes them. These are the address word, the syndrome word, `irq`, `err_class` and `bank_syn`. Read data follows `reg_addr` with no delay. The bench drives stimulus on the falling edge. It checks every result at the following falling edge, which comes after exactly one rising edge. It changes `reg_addr` only between samples. Checks that something is ignored read both words after the ignored event and before any acknowledge. Reset is released through a two-stage synchronizer, so the bench waits three cycles after releasing reset before its first stimulus.

// File: rtl/bec_pkg.sv
package bec_pkg;
  localparam int SYN_HALF_W  = 16;
  localparam int SYN_FIELD_W = 7;
  localparam int SYN_VLD_BIT = 15;
  localparam int SYN_SGL_BIT = 14;

  typedef enum logic [1:0] {
    CLS_NONE    = 2'd0,
    CLS_TIMEOUT = 2'd1,
    CLS_OVERRUN = 2'd2,
    CLS_ECC     = 2'd3
  } err_cls_t;

  function automatic logic [SYN_HALF_W-1:0] syn_keep(input logic [SYN_HALF_W-1:0] raw);
    logic [SYN_HALF_W-1:0] m;
    m = '0;
    m[SYN_VLD_BIT] = raw[SYN_VLD_BIT];
    m[SYN_SGL_BIT] = raw[SYN_SGL_BIT];
    m[SYN_FIELD_W-1:0] = raw[SYN_FIELD_W-1:0];
    return m;
  endfunction
endpackage

// File: rtl/bec_addr_fix.sv
module bec_addr_fix #(
  parameter int ADDR_W  = 28,
  parameter int FIX_W   = 12,
  parameter int FIX_OFS = 5
) (
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              is_ecc,
  input  logic              is_write,
  output logic [ADDR_W-1:0] addr_out
);
  logic [FIX_W-1:0] low_adj;
  logic             rewind;

  always_comb begin
    rewind  = is_ecc && !is_write;
    low_adj = addr_in[FIX_W-1:0] - FIX_W'(FIX_OFS);
  end

  generate
    if (ADDR_W > FIX_W) begin : g_split
      always_comb begin
        addr_out = rewind ? {addr_in[ADDR_W-1:FIX_W], low_adj} : addr_in;
      end
    end else begin : g_flat
      always_comb begin
        addr_out = rewind ? low_adj[ADDR_W-1:0] : addr_in;
      end
    end
  endgenerate
endmodule

// File: rtl/bec_syn_half.sv
module bec_syn_half
  import bec_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cap,
  input  logic                  clr,
  input  logic [SYN_HALF_W-1:0] raw,
  output logic [SYN_HALF_W-1:0] q
);
  logic                  en;
  logic [SYN_HALF_W-1:0] q_nxt;

  always_comb begin
    en    = cap || clr;
    q_nxt = cap ? syn_keep(raw) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= q_nxt;
  end

  AST_SYN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap && !clr) |=> $stable(q)); // R7

  AST_SYN_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (q[SYN_SGL_BIT-1:SYN_FIELD_W] == '0)); // R7
endmodule

// File: rtl/bus_err_capture.sv
module bus_err_capture
  import bec_pkg::*;
#(
  parameter int ADDR_W  = 28,
  parameter int FIX_W   = 12,
  parameter int FIX_OFS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_strobe,
  input  logic              ev_cpu,
  input  logic              ev_write,
  input  logic              ev_ecc,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [15:0]       syn_lo,
  input  logic [15:0]       syn_hi,
  input  logic              reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic [1:0]        err_class,
  output logic [15:0]       bank_syn
);
  localparam int EAR_W = ADDR_W + 4;

  logic rst_q1, rst_q2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  logic ack, cap, ear_en, wdata_any;
  logic ear_valid, ear_cpu, ear_wr, ear_ecc;
  logic ear_valid_nxt, ear_cpu_nxt, ear_wr_nxt, ear_ecc_nxt;
  logic [ADDR_W-1:0] ear_addr, ear_addr_nxt, fixed_addr;
  logic [EAR_W-1:0]  ear_word;
  logic [15:0]       syn_q [2];
  logic [31:0]       syn_word;
  err_cls_t          cls;

  always_comb begin
    wdata_any = |reg_wdata;
    ack       = reg_wr && (reg_addr == 1'b0);
    cap       = ev_strobe && (!ear_valid || ack);
    ear_en    = cap || ack;
  end

  bec_addr_fix #(.ADDR_W(ADDR_W), .FIX_W(FIX_W), .FIX_OFS(FIX_OFS)) u_fix (
    .addr_in (ev_addr),
    .is_ecc  (ev_ecc),
    .is_write(ev_write),
    .addr_out(fixed_addr)
  );

  always_comb begin
    ear_valid_nxt = cap;
    ear_cpu_nxt   = cap && ev_cpu;
    ear_wr_nxt    = cap && ev_write;
    ear_ecc_nxt   = cap && ev_ecc;
    ear_addr_nxt  = cap ? fixed_addr : '0;
  end

  always_ff @(posedge clk or negedge rst_q2) begin
    if (!rst_q2) begin
      ear_valid <= 1'b0;
      ear_cpu   <= 1'b0;
      ear_wr    <= 1'b0;
      ear_ecc   <= 1'b0;
      ear_addr  <= '0;
    end else if (ear_en) begin
      ear_valid <= ear_valid_nxt;
      ear_cpu   <= ear_cpu_nxt;
      ear_wr    <= ear_wr_nxt;
      ear_ecc   <= ear_ecc_nxt;
      ear_addr  <= ear_addr_nxt;
    end
  end

  logic [15:0] syn_in [2];
  always_comb begin
    syn_in[0] = syn_lo;
    syn_in[1] = syn_hi;
  end

  generate
    for (genvar b = 0; b < 2; b++) begin : g_bank
      bec_syn_half u_half (
        .clk  (clk),
        .rst_n(rst_q2),
        .cap  (cap),
        .clr  (ack),
        .raw  (syn_in[b]),
        .q    (syn_q[b])
      );
    end
  endgenerate

  always_comb begin
    ear_word = {ear_valid, ear_cpu, ear_wr, ear_ecc, ear_addr};
    syn_word = {syn_q[1], syn_q[0]};
    if (!ear_valid)   cls = CLS_NONE;
    else if (ear_ecc) cls = CLS_ECC;
    else if (ear_cpu) cls = CLS_TIMEOUT;
    else              cls = CLS_OVERRUN;
    reg_rdata = reg_addr ? syn_word : 32'(ear_word);
    irq       = ear_valid;
    err_class = cls;
    bank_syn  = !ear_valid ? 16'h0 : (ear_addr[0] ? syn_q[1] : syn_q[0]);
  end

  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_q2)
    (!ear_valid && ev_strobe) |=> irq); // R1

  AST_HOLD_FIRST: assert property (@(posedge clk) disable iff (!rst_q2)
    (ear_valid && !ack) |=> ($stable(ear_word) && $stable(syn_word))); // R2

  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_q2)
    (ack && !ev_strobe && wdata_any) |=> (!irq && ear_word == '0)); // R3

  AST_RD_REWIND: assert property (@(posedge clk) disable iff (!rst_q2)
    (cap && ev_ecc && !ev_write) |=>
      (ear_addr[FIX_W-1:0] == FIX_W'($past(ev_addr[FIX_W-1:0]) - FIX_W'(FIX_OFS)))); // R4

  AST_SYN_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_q2)
    (reg_wr && reg_addr && !cap) |=> $stable(syn_word)); // R9
endmodule

// File: tb/sim_bus_err_capture.sv
module sim_bus_err_capture;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        cpu;
    logic        wr;
    logic        ecc;
    logic [27:0] addr;
    logic [15:0] lo;
    logic [15:0] hi;
    logic [31:0] exp_ear;
    logic [1:0]  exp_cls;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 1'b0, 28'h0001234, 16'h0000, 16'h0000, 32'hC0001234, 2'd1},
    '{1'b0, 1'b1, 1'b0, 28'h0ABCDEF, 16'h1234, 16'h8001, 32'hA0ABCDEF, 2'd2},
    '{1'b1, 1'b0, 1'b1, 28'h0000003, 16'hFFFF, 16'h8055, 32'hD0000FFE, 2'd3},
    '{1'b0, 1'b0, 1'b1, 28'hFFFF00A, 16'hC041, 16'h7F83, 32'h9FFFF005, 2'd3},
    '{1'b1, 1'b1, 1'b1, 28'h0000002, 16'h8F0F, 16'h4002, 32'hF0000002, 2'd3},
    '{1'b0, 1'b0, 1'b1, 28'h0000005, 16'h4C2A, 16'hFFFF, 32'h90000000, 2'd3}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic ev_strobe, ev_cpu, ev_write, ev_ecc;
  logic [27:0] ev_addr;
  logic [15:0] syn_lo, syn_hi;
  logic reg_addr, reg_wr;
  logic [31:0] reg_wdata, reg_rdata;
  logic irq;
  logic [1:0] err_class;
  logic [15:0] bank_syn;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_err_capture u0 (
    .clk(clk), .rst_n(rst_n), .ev_strobe(ev_strobe), .ev_cpu(ev_cpu),
    .ev_write(ev_write), .ev_ecc(ev_ecc), .ev_addr(ev_addr),
    .syn_lo(syn_lo), .syn_hi(syn_hi), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .err_class(err_class), .bank_syn(bank_syn)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [15:0] keep(input logic [15:0] r);
    return r & 16'hC07F;
  endfunction

  task automatic read_reg(input logic idx, output logic [31:0] v);
    reg_addr = idx;
    #1;
    v = reg_rdata;
  endtask

  task automatic fire(input logic c, input logic w, input logic e,
                      input logic [27:0] a, input logic [15:0] l, input logic [15:0] h);
    @(negedge clk);
    ev_strobe = 1'b1; ev_cpu = c; ev_write = w; ev_ecc = e;
    ev_addr = a; syn_lo = l; syn_hi = h;
    @(negedge clk);
    ev_strobe = 1'b0;
  endtask

  task automatic wr_reg(input logic idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = idx; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, ear, syn;
    rst_n = 1'b0;
    ev_strobe = 1'b0; ev_cpu = 1'b0; ev_write = 1'b0; ev_ecc = 1'b0;
    ev_addr = '0; syn_lo = '0; syn_hi = '0;
    reg_addr = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    read_reg(1'b0, v); check("R10", "ear after reset", v, 32'h0);
    read_reg(1'b1, v); check("R10", "syn after reset", v, 32'h0);
    check("R10", "irq after reset", {31'b0, irq}, 32'h0);
    check("R10", "class after reset", {30'b0, err_class}, 32'h0);
    check("R10", "bank_syn after reset", {16'b0, bank_syn}, 32'h0);

    // Vector table: R1 R4 R5 R6 R7 R8 R3
    for (int i = 0; i < NV; i++) begin
      fire(VEC[i].cpu, VEC[i].wr, VEC[i].ecc, VEC[i].addr, VEC[i].lo, VEC[i].hi);
      check("R1", "irq after capture", {31'b0, irq}, 32'h1);
      read_reg(1'b0, v);
      check(VEC[i].ecc && !VEC[i].wr ? "R4" : "R5", "ear word", v, VEC[i].exp_ear);
      check("R6", "class", {30'b0, err_class}, {30'b0, VEC[i].exp_cls});
      read_reg(1'b1, v);
      check("R7", "syn word", v, {keep(VEC[i].hi), keep(VEC[i].lo)});
      check("R8", "bank_syn", {16'b0, bank_syn},
            {16'b0, VEC[i].exp_ear[0] ? keep(VEC[i].hi) : keep(VEC[i].lo)});
      wr_reg(1'b0, 32'h5A5A0000 ^ i);
      check("R3", "irq after ack", {31'b0, irq}, 32'h0);
      read_reg(1'b0, v); check("R3", "ear after ack", v, 32'h0);
    end

    // R2: later event ignored while held
    fire(1'b1, 1'b0, 1'b0, 28'h0000100, 16'h8001, 16'h0000);
    fire(1'b0, 1'b1, 1'b1, 28'h0000201, 16'hFFFF, 16'hFFFF);
    read_reg(1'b0, ear); check("R2", "ear keeps first", ear, 32'hC0000100);
    read_reg(1'b1, syn); check("R2", "syn keeps first", syn, 32'h00008001);

    // R9: write to syndrome register ignored
    wr_reg(1'b1, 32'hFFFFFFFF);
    read_reg(1'b1, syn); check("R9", "syn after write", syn, 32'h00008001);
    read_reg(1'b0, ear); check("R9", "ear after syn write", ear, 32'hC0000100);
    check("R9", "irq after syn write", {31'b0, irq}, 32'h1);

    // R3: ack with zero data still clears; ack with strobe captures new
    wr_reg(1'b0, 32'h0);
    check("R3", "irq after zero-data ack", {31'b0, irq}, 32'h0);
    fire(1'b1, 1'b0, 1'b0, 28'h0000300, 16'h0000, 16'h0000);
    @(negedge clk);
    ev_strobe = 1'b1; ev_cpu = 1'b0; ev_write = 1'b0; ev_ecc = 1'b0;
    ev_addr = 28'h0000401; syn_lo = 16'h0000; syn_hi = 16'hC003;
    reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 32'h1;
    @(negedge clk);
    ev_strobe = 1'b0; reg_wr = 1'b0;
    read_reg(1'b0, ear); check("R3", "ack+strobe stores new", ear, 32'h80000401);
    check("R6", "class overrun", {30'b0, err_class}, 32'h2);
    check("R8", "bank_syn high", {16'b0, bank_syn}, 32'h0000C003);
    wr_reg(1'b0, 32'h0);
    check("R8", "bank_syn cleared", {16'b0, bank_syn}, 32'h0);

    // R4 wrap at field boundary with upper bits kept
    fire(1'b0, 1'b0, 1'b1, 28'hABC1004, 16'h0000, 16'h0000);
    read_reg(1'b0, ear); check("R4", "wrap keeps upper", ear, 32'h9ABC1FFF);
    wr_reg(1'b0, 32'h0);

    finish_run();
  end
endmodule